// File: doc/BRIEF.md
# Transient Response Mode Controller

This block watches a digitized sample of the regulated output voltage and decides whether the power stage should run normally, push harder, or back off. Each sample arrives with a one-cycle strobe. Five programmable levels are compared against the sample: a sag trigger, a sag recovery, a surge trigger, a surge recovery and a start-up completion level. From these comparisons the block keeps a registered operating mode and drives two override selects. One select scales the switch on-time and the other forces the switching frequency.

Both excursion detectors are hysteretic. A sag enters boost mode, which stretches the on-time by half and forces maximum frequency. The block leaves boost only when the sample climbs past a higher recovery level. A surge enters cut-back mode, which forces both the on-time and the frequency to their minimums. The block leaves cut-back only when the sample falls below a lower recovery level. None of this is active until the output has first risen past the start-up completion level. That condition is held in a sticky arm flag, which only reset clears. The on-time arithmetic and the analog sampling belong to neighbouring blocks.

Top module: `trm_ctrl`

## Requirements
- R1: After reset, `ton_sel_o` is 0 (nominal), `frq_ovr_o` is 0 (no override) and `armed_o` is 0.
- R2: `armed_o` becomes 1 after the first strobe whose sample is strictly above `lvl_start_i`. It then stays 1 whatever later samples are, until reset.
- R3: While the block is not armed, the override outputs stay 0 for any sample. Excursion detection starts with the strobe after the one that arms the block.
- R4: From normal mode, a strobed sample strictly below `lvl_low_trig_i` enters boost mode: `ton_sel_o` = 1 (on-time x1.5) and `frq_ovr_o` = 1 (maximum frequency).
- R5: Boost mode persists while strobed samples are at or below `lvl_low_rec_i`. The first sample strictly above it returns the block to normal (both outputs 0).
- R6: A strobed sample strictly above `lvl_high_trig_i` enters cut-back mode: `ton_sel_o` = 2 (minimum on-time) and `frq_ovr_o` = 2 (minimum frequency).
- R7: Cut-back mode persists while strobed samples are at or above `lvl_high_rec_i`. The first sample strictly below it returns the block to normal.
- R8: Boost and cut-back never coexist. A surge trigger wins over a sag trigger in the same sample, even when the levels are misordered. A surge trigger while in boost moves the block straight to cut-back.
- R9: The outputs change only on the clock edge that samples a strobe. Sample or level changes without a strobe have no effect.
- R10: All comparisons are strict. A sample equal to a trigger or start level does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle strobe marking a valid feedback sample |
| fb_i | input | FB_W | Digitized output-voltage feedback sample |
| lvl_low_trig_i | input | FB_W | Sag trigger level |
| lvl_low_rec_i | input | FB_W | Sag recovery level |
| lvl_high_trig_i | input | FB_W | Surge trigger level |
| lvl_high_rec_i | input | FB_W | Surge recovery level |
| lvl_start_i | input | FB_W | Start-up completion level |
| ton_sel_o | output | 2 | On-time select: 0 nominal, 1 stretch x1.5, 2 minimum |
| frq_ovr_o | output | 2 | Frequency override: 0 none, 1 force maximum, 2 force minimum |
| armed_o | output | 1 | Transient handling enabled |

## Verification
The hardest case to reach is the one where both trigger comparators fire on the same sample. With sane levels this cannot happen, because a sample cannot be below the sag trigger and above the surge trigger at once. The bench therefore reprograms the sag trigger above the surge trigger while the block sits in normal mode, then strobes a sample between them to show that cut-back wins. A second hard case is the direct jump from boost to cut-back, which needs one strobe to leap from below the sag trigger past the surge trigger. The bench also holds a changed sample without a strobe for several cycles, to show that the registered outputs ignore it.

// File: rtl/trm_pkg.sv
package trm_pkg;
  typedef enum logic [1:0] {
    TON_NOM     = 2'd0,
    TON_STRETCH = 2'd1,
    TON_SHRINK  = 2'd2
  } ton_sel_e;

  typedef enum logic [1:0] {
    FRQ_FREE = 2'd0,
    FRQ_MAX  = 2'd1,
    FRQ_MIN  = 2'd2
  } frq_ovr_e;

  // comparator slots; bit set in LVL_ABOVE means "hit when sample is above"
  localparam int unsigned LVL_N       = 5;
  localparam int unsigned IDX_LO_TRIG = 0;
  localparam int unsigned IDX_LO_REC  = 1;
  localparam int unsigned IDX_HI_TRIG = 2;
  localparam int unsigned IDX_HI_REC  = 3;
  localparam int unsigned IDX_START   = 4;
  localparam logic [LVL_N-1:0] LVL_ABOVE = 5'b10110;
endpackage

// File: rtl/trm_cmp_bank.sv
module trm_cmp_bank #(
  parameter int unsigned W = 10,
  parameter int unsigned N = 5,
  parameter logic [N-1:0] ABOVE = '0
) (
  input  logic [W-1:0]        fb_i,
  input  logic [N-1:0][W-1:0] lvl_i,
  output logic [N-1:0]        hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    if (ABOVE[i]) begin : g_gt
      assign hit_o[i] = fb_i > lvl_i[i];
    end else begin : g_lt
      assign hit_o[i] = fb_i < lvl_i[i];
    end
  end
endmodule

// File: rtl/trm_start_gate.sv
module trm_start_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic cross_i,
  output logic armed_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 armed_q <= 1'b0;
    else if (strobe_i && cross_i) armed_q <= 1'b1;
  end

  assign armed_o = armed_q;

  assert_sticky_arm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);
endmodule

// File: rtl/trm_excursion.sv
module trm_excursion (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic active_o,
  output logic next_o
);
  logic active_q;

  always_comb begin
    if (!step_i)      next_o = active_q;
    else if (kill_i)  next_o = 1'b0;
    else if (active_q) next_o = !clr_i;
    else              next_o = set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) active_q <= 1'b0;
    else         active_q <= next_o;
  end

  assign active_o = active_q;

  // hysteresis: without a recovery hit or an override, an active excursion persists
  assert_hyst_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !kill_i && !(step_i && clr_i)) |=> active_q);
endmodule

// File: rtl/trm_out_stage.sv
module trm_out_stage
  import trm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  input  logic     boost_i,
  input  logic     cut_i,
  output ton_sel_e ton_sel_o,
  output frq_ovr_e frq_ovr_o
);
  ton_sel_e ton_q;
  frq_ovr_e frq_q;
  ton_sel_e ton_d;
  frq_ovr_e frq_d;

  always_comb begin
    ton_d = TON_NOM;
    frq_d = FRQ_FREE;
    if (cut_i) begin
      ton_d = TON_SHRINK;
      frq_d = FRQ_MIN;
    end else if (boost_i) begin
      ton_d = TON_STRETCH;
      frq_d = FRQ_MAX;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ton_q <= TON_NOM;
      frq_q <= FRQ_FREE;
    end else if (step_i) begin
      ton_q <= ton_d;
      frq_q <= frq_d;
    end
  end

  assign ton_sel_o = ton_q;
  assign frq_ovr_o = frq_q;

  assert_strobe_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(ton_q) && $stable(frq_q)));
endmodule

// File: rtl/trm_ctrl.sv
module trm_ctrl
  import trm_pkg::*;
#(
  parameter int unsigned FB_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            smp_stb_i,
  input  logic [FB_W-1:0] fb_i,
  input  logic [FB_W-1:0] lvl_low_trig_i,
  input  logic [FB_W-1:0] lvl_low_rec_i,
  input  logic [FB_W-1:0] lvl_high_trig_i,
  input  logic [FB_W-1:0] lvl_high_rec_i,
  input  logic [FB_W-1:0] lvl_start_i,
  output logic [1:0]      ton_sel_o,
  output logic [1:0]      frq_ovr_o,
  output logic            armed_o
);
  logic [LVL_N-1:0][FB_W-1:0] lvl;
  logic [LVL_N-1:0]           hit;
  logic armed, step;
  logic boost_q, boost_n, cut_q, cut_n;
  ton_sel_e ton_sel;
  frq_ovr_e frq_ovr;

  always_comb begin
    lvl              = '0;
    lvl[IDX_LO_TRIG] = lvl_low_trig_i;
    lvl[IDX_LO_REC]  = lvl_low_rec_i;
    lvl[IDX_HI_TRIG] = lvl_high_trig_i;
    lvl[IDX_HI_REC]  = lvl_high_rec_i;
    lvl[IDX_START]   = lvl_start_i;
  end

  trm_cmp_bank #(.W(FB_W), .N(LVL_N), .ABOVE(LVL_ABOVE)) u_cmp (
    .fb_i (fb_i),
    .lvl_i(lvl),
    .hit_o(hit)
  );

  trm_start_gate u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(smp_stb_i),
    .cross_i (hit[IDX_START]),
    .armed_o (armed)
  );

  // detection uses the arm state held before this strobe
  assign step = smp_stb_i && armed;

  trm_excursion u_cut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .set_i   (hit[IDX_HI_TRIG]),
    .clr_i   (hit[IDX_HI_REC]),
    .kill_i  (1'b0),
    .active_o(cut_q),
    .next_o  (cut_n)
  );

  // surge wins: sag state is cleared whenever cut-back is (or becomes) active
  trm_excursion u_boost (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .set_i   (hit[IDX_LO_TRIG]),
    .clr_i   (hit[IDX_LO_REC]),
    .kill_i  (cut_n),
    .active_o(boost_q),
    .next_o  (boost_n)
  );

  trm_out_stage u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (smp_stb_i),
    .boost_i  (boost_n),
    .cut_i    (cut_n),
    .ton_sel_o(ton_sel),
    .frq_ovr_o(frq_ovr)
  );

  assign ton_sel_o = ton_sel;
  assign frq_ovr_o = frq_ovr;
  assign armed_o   = armed;

  assert_mode_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(boost_q && cut_q));

  assert_surge_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && armed && hit[IDX_HI_TRIG]) |=> (ton_sel_o == TON_SHRINK && frq_ovr_o == FRQ_MIN));

  assert_idle_unarmed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (ton_sel_o == TON_NOM && frq_ovr_o == FRQ_FREE));

  assert_sag_enter_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_stb_i && armed && !boost_q && !cut_q && hit[IDX_LO_TRIG] && !hit[IDX_HI_TRIG])
      |=> (ton_sel_o == TON_STRETCH && frq_ovr_o == FRQ_MAX));
endmodule

// File: tb/sim_trm_ctrl.sv
module sim_trm_ctrl;
  localparam int unsigned W = 10;

  typedef struct {
    logic [1:0] ton;
    logic [1:0] frq;
    logic       arm;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic [W-1:0] fb = '0;
  logic [W-1:0] lo_trig = 10'd100, lo_rec = 10'd120;
  logic [W-1:0] hi_trig = 10'd200, hi_rec = 10'd180, st_lvl = 10'd150;
  logic [1:0] ton_sel, frq_ovr;
  logic armed;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  trm_ctrl #(.FB_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_stb_i(stb), .fb_i(fb),
    .lvl_low_trig_i(lo_trig), .lvl_low_rec_i(lo_rec),
    .lvl_high_trig_i(hi_trig), .lvl_high_rec_i(hi_rec), .lvl_start_i(st_lvl),
    .ton_sel_o(ton_sel), .frq_ovr_o(frq_ovr), .armed_o(armed)
  );

  function automatic void compare(exp_t e);
    n_chk++;
    if (ton_sel !== e.ton || frq_ovr !== e.frq || armed !== e.arm) begin
      n_bad++;
      $display("FAIL %s: got ton=%0d frq=%0d arm=%0b, expected ton=%0d frq=%0d arm=%0b",
               e.tag, ton_sel, frq_ovr, armed, e.ton, e.frq, e.arm);
    end
  endfunction

  // driver: strobe one sample, queue its expected result
  task automatic drive(input logic [W-1:0] v, input logic [1:0] t, input logic [1:0] f,
                       input logic a, input string tag);
    exp_t e;
    e.ton = t; e.frq = f; e.arm = a; e.tag = tag;
    @(negedge clk);
    fb = v;
    stb = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_now(input logic [1:0] t, input logic [1:0] f,
                           input logic a, input string tag);
    exp_t e;
    e.ton = t; e.frq = f; e.arm = a; e.tag = tag;
    @(negedge clk);
    compare(e);
  endtask

  // monitor: result is visible at the falling edge after the strobed rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (stb) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL scoreboard: got result with empty queue, expected none");
        end else compare(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_now(2'd0, 2'd0, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    drive(10'd50,  2'd0, 2'd0, 1'b0, "R3 sag before arm ignored");
    drive(10'd150, 2'd0, 2'd0, 1'b0, "R10 equal start level does not arm");
    drive(10'd151, 2'd0, 2'd0, 1'b1, "R2 arm above start level");
    drive(10'd100, 2'd0, 2'd0, 1'b1, "R10 equal sag trigger stays normal");
    drive(10'd99,  2'd1, 2'd1, 1'b1, "R4 sag enters boost");
    drive(10'd110, 2'd1, 2'd1, 1'b1, "R5 boost held between levels");
    drive(10'd120, 2'd1, 2'd1, 1'b1, "R5 boost held at recovery level");
    drive(10'd121, 2'd0, 2'd0, 1'b1, "R5 boost exits above recovery");
    drive(10'd200, 2'd0, 2'd0, 1'b1, "R10 equal surge trigger stays normal");
    drive(10'd201, 2'd2, 2'd2, 1'b1, "R6 surge enters cut-back");
    drive(10'd190, 2'd2, 2'd2, 1'b1, "R7 cut-back held between levels");
    drive(10'd180, 2'd2, 2'd2, 1'b1, "R7 cut-back held at recovery level");
    drive(10'd179, 2'd0, 2'd0, 1'b1, "R7 cut-back exits below recovery");
    drive(10'd90,  2'd1, 2'd1, 1'b1, "R4 second sag entry");
    // sample change without strobe
    @(negedge clk);
    fb = 10'd250;
    repeat (3) @(negedge clk);
    check_now(2'd1, 2'd1, 1'b1, "R9 no strobe no change");
    drive(10'd250, 2'd2, 2'd2, 1'b1, "R8 surge from boost goes straight to cut-back");
    drive(10'd150, 2'd0, 2'd0, 1'b1, "R7 back to normal");
    drive(10'd0,   2'd1, 2'd1, 1'b1, "R2 arm sticky on low sample");
    drive(10'd150, 2'd0, 2'd0, 1'b1, "R5 normal before misorder test");
    @(negedge clk);
    lo_trig = 10'd300;
    drive(10'd250, 2'd2, 2'd2, 1'b1, "R8 surge beats sag on same sample");
    lo_trig = 10'd100;
    @(negedge clk);
    rst_n = 1'b0;
    check_now(2'd0, 2'd0, 1'b0, "R1 reset clears arm and modes");
    rst_n = 1'b1;
    drive(10'd50, 2'd0, 2'd0, 1'b0, "R3 rearm required after reset");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule